// File: doc/BRIEF.md
# Pipeline-Aligned Bus Target with Wait States

This block is a memory-backed target on a pipelined shared bus. On the bus, each transfer has an address phase followed by a data phase. The target holds a small word array with byte lanes. It adds a fixed number of wait states, set by a parameter, to each transfer it owns. It pulls its own ready output low to stretch its data phase. It also watches the bus-wide ready input, which the interconnect forms from whichever target currently owns the data phase.

An address phase is taken as a new transfer only on a cycle where the bus-wide ready input is high. A target that is selected while another target is still stalling the bus therefore keeps its request pending. It starts its data phase only after the bus advances. Write data is taken in the last data-phase cycle, and read data is driven in that same cycle. The response is always OKAY.

The bus has no valid/ready stream. Back-pressure is the ready pair itself: the master holds its address and control while the bus-wide ready input is low, and the target holds its ready output low for its wait cycles.

Top module: `ahbs_target`

## Requirements
- R1: After reset, `rdy_out` is 1, `t_rdata` is 0 and no transfer is pending.
- R2: A transfer is accepted at a clock edge only if, in that cycle, `t_sel` is 1, `bus_rdy_in` is 1 and `t_trans` is NONSEQ (2'b10) or SEQ (2'b11). A selected request seen while `bus_rdy_in` is 0 is not captured.
- R3: An accepted transfer has a data phase of WAITS+1 cycles, starting in the cycle after acceptance. `rdy_out` is 0 for the first WAITS cycles and 1 in the last. With WAITS=0 the transfer completes in its first data-phase cycle.
- R4: A write stores `t_wdata` in the last data-phase cycle into the lanes chosen by `t_size` and the low address bits. `t_size` 0 selects one byte lane, 1 selects two lanes aligned to 2, and 2 selects the whole word. The word index is `t_addr[ADDR_W-1:2]`.
- R5: A read drives the full stored word at the captured word index on `t_rdata` in the last data-phase cycle. In every other cycle `t_rdata` is 0.
- R6: IDLE (2'b00) and BUSY (2'b01) do not start a data phase and do not change storage. `rdy_out` stays 1 in the following cycle.
- R7: `t_resp` is always 0 (OKAY).
- R8: Outside its own data phase the target drives `rdy_out` high.
- R9: When the target is selected while another target holds `bus_rdy_in` low, a zero-wait configuration completes exactly one cycle after `bus_rdy_in` rises, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t_sel | input | 1 | Decoder select for this target |
| t_addr | input | ADDR_W | Byte address of the address phase |
| t_trans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| t_write | input | 1 | 1 for write, 0 for read |
| t_size | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| t_wdata | input | DATA_W | Write data, valid in the data phase |
| bus_rdy_in | input | 1 | Bus-wide ready from the interconnect |
| rdy_out | output | 1 | This target's own ready |
| t_rdata | output | DATA_W | Read data, valid in the last data-phase cycle |
| t_resp | output | 1 | Response, always OKAY (0) |

## Verification
Acceptance at cycle c puts the first data-phase cycle at c+1. The completing cycle is c+1+WAITS, so a zero-wait target completes at c+1. When the target waits behind a peer, c is the cycle in which the bus-wide ready rises. For each transfer, the driver computes the start and completion cycles from its own cycle counter and queues them with the expected read word. The monitor samples on the falling edge. It expects ready low before the completion cycle and ready high, with the data, exactly at it. During a peer stall, and after IDLE or BUSY, the bench checks at the falling edge that ready stays high and that no read data appears.

// File: rtl/ahbs_pkg.sv
package ahbs_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2
  } size_e;

  typedef struct packed {
    logic       busy;
    logic       last;
  } phase_t;
endpackage

// File: rtl/ahbs_capture.sv
module ahbs_capture #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              write_in,
  input  logic [2:0]        size_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [2:0]        size_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
    end else if (take) begin
      addr_q  <= addr_in;
      write_q <= write_in;
      size_q  <= size_in;
    end
  end
endmodule

// File: rtl/ahbs_waitgen.sv
module ahbs_waitgen
  import ahbs_pkg::*;
#(
  parameter int WAITS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t ph
);
  localparam int CW = (WAITS > 0) ? $clog2(WAITS + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WAITS);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign ph.busy = busy_q;
  assign ph.last = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q || ph.last) begin
      busy_q <= start;
      cnt_q  <= LOAD;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ahbs_store.sv
module ahbs_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = ADDR_W - OFF_W;
  localparam int WORDS = 1 << IDX_W;

  logic [IDX_W-1:0] widx;
  logic [OFF_W-1:0] off;
  logic [LANES-1:0] mask;

  assign widx = addr[ADDR_W-1:OFF_W];
  assign off  = addr[OFF_W-1:0];

  always_comb begin
    int nb;
    int base;
    case (size)
      3'd0:    nb = 1;
      3'd1:    nb = (LANES >= 2) ? 2 : LANES;
      default: nb = LANES;
    endcase
    base = int'(off) & ~(nb - 1);
    for (int l = 0; l < LANES; l++) begin
      mask[l] = (l >= base) && (l < base + nb);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bank [WORDS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) bank[w] <= 8'h00;
      end else if (wr_en && mask[l]) begin
        bank[widx] <= wdata[l*8 +: 8];
      end
    end
    assign rd_word[l*8 +: 8] = bank[widx];
  end
endmodule

// File: rtl/ahbs_target.sv
module ahbs_target
  import ahbs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int WAITS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t_sel,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic [1:0]        t_trans,
  input  logic              t_write,
  input  logic [2:0]        t_size,
  input  logic [DATA_W-1:0] t_wdata,
  input  logic              bus_rdy_in,
  output logic              rdy_out,
  output logic [DATA_W-1:0] t_rdata,
  output logic              t_resp
);
  phase_t            ph;
  logic              ph_busy;
  logic              accept;
  logic              take;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_write;
  logic [2:0]        cap_size;
  logic [DATA_W-1:0] rd_word;

  assign accept  = t_sel && bus_rdy_in &&
                   (t_trans == TR_NSEQ || t_trans == TR_SEQ);
  assign take    = accept && (!ph.busy || ph.last);
  assign ph_busy = ph.busy;

  ahbs_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .addr_in  (t_addr),
    .write_in (t_write),
    .size_in  (t_size),
    .addr_q   (cap_addr),
    .write_q  (cap_write),
    .size_q   (cap_size)
  );

  ahbs_waitgen #(.WAITS(WAITS)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take),
    .ph    (ph)
  );

  ahbs_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ph.last && cap_write),
    .addr    (cap_addr),
    .size    (cap_size),
    .wdata   (t_wdata),
    .rd_word (rd_word)
  );

  assign rdy_out = !ph.busy || ph.last;
  assign t_rdata = (ph.last && !cap_write) ? rd_word : '0;
  assign t_resp  = 1'b0;
endmodule

// File: rtl/ahbs_target_chk.sv
module ahbs_target_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic [1:0]        trans,
  input logic              bus_rdy,
  input logic              rdy_out,
  input logic [DATA_W-1:0] rdata,
  input logic              resp,
  input logic              ph_busy
);
  AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    resp == 1'b0); // R7

  AST_NO_CAPTURE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph_busy && !bus_rdy) |=> !ph_busy); // R2

  AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph_busy && sel && bus_rdy && trans[1]) |=> ph_busy); // R2

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_busy |-> rdy_out); // R8

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_busy && !rdy_out) |=> ph_busy); // R3

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_busy && rdy_out) |-> rdata == '0); // R5
endmodule

bind ahbs_target ahbs_target_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (t_sel),
  .trans   (t_trans),
  .bus_rdy (bus_rdy_in),
  .rdy_out (rdy_out),
  .rdata   (t_rdata),
  .resp    (t_resp),
  .ph_busy (ph_busy)
);

// File: tb/ahbs_target_tb_top.sv
`timescale 1ns/1ps
module ahbs_target_tb_top;
  localparam int SLOW_W = 2;

  typedef struct {
    int          who;
    int          start;
    int          due;
    bit          rd;
    logic [31:0] exp;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        sel_s = 0, sel_f = 0;
  logic [7:0]  addr = '0;
  logic [1:0]  trans = '0;
  logic        wr = 0;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        peer_rdy = 1'b1;
  int          owner = 0;

  logic        rdy_s, rdy_f, resp_s, resp_f, bus_rdy;
  logic [31:0] rdata_s, rdata_f;

  assign bus_rdy = (owner == 3) ? peer_rdy :
                   (owner == 1) ? rdy_s :
                   (owner == 2) ? rdy_f : 1'b1;

  ahbs_target #(.WAITS(SLOW_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .t_sel(sel_s), .t_addr(addr), .t_trans(trans),
    .t_write(wr), .t_size(size), .t_wdata(wdata), .bus_rdy_in(bus_rdy),
    .rdy_out(rdy_s), .t_rdata(rdata_s), .t_resp(resp_s));

  ahbs_target #(.WAITS(0)) fast_i (
    .clk(clk), .rst_n(rst_n), .t_sel(sel_f), .t_addr(addr), .t_trans(trans),
    .t_write(wr), .t_size(size), .t_wdata(wdata), .bus_rdy_in(bus_rdy),
    .rdy_out(rdy_f), .t_rdata(rdata_f), .t_resp(resp_f));

  int total = 0;
  int bad = 0;
  item_t q[$];
  logic [31:0] model [1:2][0:63];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(input int who, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] d);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    int base = int'(a[1:0]) & ~(nb - 1);
    for (int l = base; l < base + nb; l++) model[who][a[7:2]][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic push(input int who, input int st, input int w, input bit rd,
                      input logic [7:0] a);
    item_t it;
    it.who = who; it.start = st; it.due = st + w; it.rd = rd;
    it.exp = model[who][a[7:2]];
    q.push_back(it);
  endtask

  // driver: one transfer, address phase in the current cycle
  task automatic run(input int who, input bit w_n, input logic [7:0] a,
                     input logic [2:0] sz, input logic [31:0] d);
    int w = (who == 1) ? SLOW_W : 0;
    sel_s = (who == 1); sel_f = (who == 2);
    trans = 2'b10; addr = a; wr = w_n; size = sz;
    if (w_n) model_wr(who, a, sz, d);
    push(who, cyc + 1, w, !w_n, a);
    @(posedge clk); #1;
    sel_s = 0; sel_f = 0; trans = 2'b00; wdata = d; owner = who;
    repeat (w + 1) begin @(posedge clk); #1; end
    owner = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && cyc >= q[0].start) begin
      logic        r;
      logic [31:0] rd;
      logic        rs;
      r  = (q[0].who == 1) ? rdy_s : rdy_f;
      rd = (q[0].who == 1) ? rdata_s : rdata_f;
      rs = (q[0].who == 1) ? resp_s : resp_f;
      if (cyc < q[0].due) begin
        chk(r == 1'b0, "R3 wait cycle ready low", 32'(r), 32'd0);
      end else begin
        chk(r == 1'b1, "R3 final cycle ready high", 32'(r), 32'd1);
        if (q[0].rd) chk(rd == q[0].exp, "R5 R4 read data", rd, q[0].exp);
        chk(rs == 1'b0, "R7 response okay", 32'(rs), 32'd0);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin model[1][i] = '0; model[2][i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdy_s == 1 && rdy_f == 1, "R1 reset ready high", 32'({rdy_s, rdy_f}), 32'd3);
    chk(rdata_s == 0 && rdata_f == 0, "R1 reset rdata zero", rdata_s | rdata_f, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 R4 R5: slow target, word, byte and halfword lanes
    run(1, 1, 8'h10, 3'd2, 32'h11223344);
    run(1, 0, 8'h10, 3'd2, 32'h0);
    run(1, 1, 8'h12, 3'd0, 32'h00AA0000);
    run(1, 1, 8'h11, 3'd1, 32'h0000BEEF);
    run(1, 0, 8'h10, 3'd2, 32'h0);
    run(1, 1, 8'h23, 3'd0, 32'h5A000000);
    run(1, 0, 8'h20, 3'd2, 32'h0);

    // R3 zero waits on fast target, then back-to-back pipelined write/read
    run(2, 1, 8'h40, 3'd2, 32'hCAFEF00D);
    run(2, 0, 8'h40, 3'd2, 32'h0);
    sel_f = 1; trans = 2'b11; addr = 8'h44; wr = 1; size = 3'd2;
    model_wr(2, 8'h44, 3'd2, 32'h600DD00D);
    push(2, cyc + 1, 0, 0, 8'h44);
    @(posedge clk); #1;
    owner = 2; wdata = 32'h600DD00D; wr = 0; trans = 2'b10;
    push(2, cyc + 1, 0, 1, 8'h44);
    @(negedge clk);
    chk(rdy_s == 1, "R8 unselected target ready high", 32'(rdy_s), 32'd1);
    @(posedge clk); #1;
    sel_f = 0; trans = 2'b00;
    @(posedge clk); #1;
    owner = 0;

    // R6: IDLE and BUSY on slow target leave storage alone
    for (int k = 0; k < 2; k++) begin
      sel_s = 1; trans = 2'(k); addr = 8'h10; wr = 1; size = 3'd2;
      @(posedge clk); #1;
      sel_s = 0; trans = 2'b00; wdata = 32'hDEADBEEF;
      @(negedge clk);
      chk(rdy_s == 1, "R6 no data phase after idle/busy", 32'(rdy_s), 32'd1);
      chk(rdata_s == 0, "R6 no read data after idle/busy", rdata_s, 32'd0);
      @(posedge clk); #1;
    end
    run(1, 0, 8'h10, 3'd2, 32'h0);

    // R9 R2: fast target selected behind a stalled peer
    owner = 3; peer_rdy = 0;
    sel_f = 1; trans = 2'b10; addr = 8'h40; wr = 0; size = 3'd2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rdy_f == 1, "R9 R2 no data phase during peer stall", 32'(rdy_f), 32'd1);
      chk(rdata_f == 0, "R9 R2 no early read data", rdata_f, 32'd0);
      @(posedge clk); #1;
    end
    peer_rdy = 1;
    push(2, cyc + 1, 0, 1, 8'h40);
    @(posedge clk); #1;
    owner = 2; sel_f = 0; trans = 2'b00; peer_rdy = 0;
    @(posedge clk); #1;
    owner = 0; peer_rdy = 1;

    repeat (3) @(posedge clk);
    chk(q.size() == 0, "R3 all transfers completed", 32'(q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule